// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This block is an array of identical 32-bit lanes. Each lane splits its slice of two source vectors into four byte pairs. The byte from the first source is read as unsigned and the byte from the second source is read as two's complement. The lane multiplies the four pairs, adds the four products together, and adds that sum to the lane's incoming 32-bit accumulator value. The result replaces the accumulator lane, and any carry above bit 31 is dropped.

The vector width is a parameter, and every lane is updated on every operation. A one-cycle start pulse captures all inputs. The updated vector and a one-cycle done pulse appear on the next clock cycle. The output then holds its value until the next start.

Top module: `usdot_accum`

## Requirements
- R1: Lane e uses bits [32e+31:32e] of every vector. Byte i of a lane (i = 0..3) is the lane's bits [8i+7:8i], and byte i of the first source is paired with byte i of the second source.
- R2: Each byte of the first source is treated as an unsigned value in the range 0..255.
- R3: Each byte of the second source is treated as a two's-complement value in the range -128..127.
- R4: Each result lane equals the accumulator lane plus the sum of its four byte products, taken modulo 2^32.
- R5: The lane count is VL/32, where VL is one of 128, 256 or 512. All lanes are computed independently, and no lane is ever masked.
- R6: When start_i is sampled high, acc_o carries the result and done_o is 1 on the following clock edge.
- R7: In a cycle after start_i was low, done_o is 0 and acc_o keeps its previous value, whatever the data inputs do.
- R8: A synchronous active-high reset clears acc_o and done_o to 0.
- R9: If all bytes of one source are zero, the result equals the accumulator input.
- R10: The extreme products wrap correctly. With 255 × -128 in all four positions the lane sum is -130560. With 255 × 127 the lane sum is +129540.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Captures the inputs and starts one operation |
| src_a_i | input | VL | First source vector, unsigned bytes |
| src_b_i | input | VL | Second source vector, signed bytes |
| acc_i | input | VL | Accumulator vector to add into |
| acc_o | output | VL | Updated accumulator vector, registered |
| done_o | output | 1 | One-cycle pulse marking a valid result |

## Verification
The main sweep steps the unsigned byte across its whole range in strides. It pairs that byte with every signed value from -128 to 127, and each of the sixteen byte positions gets a different offset of the pair. This exposes any swap of byte positions or lanes, and any mix-up of signedness: a sign-extended first source or a zero-extended second source gives a different answer once a byte is 128 or above. Directed vectors push the extreme products against accumulators near 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, in different lanes, so that the 32-bit wrap in each direction is visible. Zero sources show that the accumulator passes through unchanged. Idle cycles with changing inputs show that the result and the done pulse are held.

// File: rtl/usdot_pkg.sv
package usdot_pkg;
    localparam int LANE_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int LANE_BYTES = LANE_W / BYTE_W;
    localparam int PROD_W    = 2 * BYTE_W + 1;
    localparam int SUM_W     = PROD_W + $clog2(LANE_BYTES);

    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic [LANE_W-1:0]        lane_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ubyte;
        logic [BYTE_W-1:0] sbyte;
    } byte_pair_t;

    // Unsigned byte times signed byte, exact in PROD_W bits.
    function automatic prod_t mul_us(input byte_pair_t p);
        prod_t ue;
        prod_t se;
        ue = prod_t'({{(PROD_W-BYTE_W){1'b0}}, p.ubyte});
        se = prod_t'({{(PROD_W-BYTE_W){p.sbyte[BYTE_W-1]}}, p.sbyte});
        return ue * se;
    endfunction

    function automatic lane_t widen_sum(input sum_t s);
        return lane_t'({{(LANE_W-SUM_W){s[SUM_W-1]}}, s});
    endfunction
endpackage

// File: rtl/usdot_mul.sv
module usdot_mul
    import usdot_pkg::*;
(
    input  byte_pair_t pair_i,
    output prod_t      prod_o
);
    assign prod_o = mul_us(pair_i);

    // The product of an unsigned and a signed byte lies in [-32640, 32385].
    always_comb begin
        a_r3_prod_range: assert (prod_o >= -32640 && prod_o <= 32385);
    end
endmodule

// File: rtl/usdot_lane.sv
module usdot_lane
    import usdot_pkg::*;
(
    input  lane_t a_i,
    input  lane_t b_i,
    input  lane_t acc_i,
    output lane_t res_o
);
    prod_t prods [LANE_BYTES];
    sum_t  lane_sum;

    for (genvar i = 0; i < LANE_BYTES; i++) begin : g_byte
        byte_pair_t pr;
        assign pr.ubyte = a_i[BYTE_W*i +: BYTE_W];
        assign pr.sbyte = b_i[BYTE_W*i +: BYTE_W];
        usdot_mul u_mul (.pair_i(pr), .prod_o(prods[i]));
    end

    always_comb begin
        lane_sum = '0;
        for (int i = 0; i < LANE_BYTES; i++) begin
            lane_sum = lane_sum + sum_t'(prods[i]);
        end
    end

    assign res_o = acc_i + widen_sum(lane_sum);

    always_comb begin
        a_r10_sum_range: assert (lane_sum >= -130560 && lane_sum <= 129540);
        if (a_i == '0 || b_i == '0) begin
            a_r9_zero_source: assert (lane_sum == '0);
        end
    end
endmodule

// File: rtl/usdot_accum.sv
module usdot_accum
    import usdot_pkg::*;
#(
    parameter int VL = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [VL-1:0] src_a_i,
    input  logic [VL-1:0] src_b_i,
    input  logic [VL-1:0] acc_i,
    output logic [VL-1:0] acc_o,
    output logic          done_o
);
    localparam int LANES = VL / LANE_W;

    logic [VL-1:0] next_acc;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        usdot_lane u_lane (
            .a_i   (src_a_i[LANE_W*e +: LANE_W]),
            .b_i   (src_b_i[LANE_W*e +: LANE_W]),
            .acc_i (acc_i[LANE_W*e +: LANE_W]),
            .res_o (next_acc[LANE_W*e +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) acc_o <= next_acc;
        end
    end

    a_r6_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);
    a_r7_no_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(acc_o));
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && !done_o));
endmodule

// File: tb/usdot_accum_tb.sv
module usdot_accum_tb_top;
    localparam int VL = 128;
    localparam int LANES = VL / 32;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [VL-1:0] src_a_i = '0;
    logic [VL-1:0] src_b_i = '0;
    logic [VL-1:0] acc_i = '0;
    logic [VL-1:0] acc_o;
    logic          done_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    usdot_accum #(.VL(VL)) dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [VL-1:0] model(input logic [VL-1:0] a,
                                           input logic [VL-1:0] b,
                                           input logic [VL-1:0] c);
        logic [VL-1:0] r;
        for (int e = 0; e < LANES; e++) begin
            int s = 0;
            for (int i = 0; i < 4; i++) begin
                int ua = int'(a[32*e + 8*i +: 8]);
                int sb = int'($signed(b[32*e + 8*i +: 8]));
                s += ua * sb;
            end
            r[32*e +: 32] = c[32*e +: 32] + 32'(s);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [VL-1:0] a, input logic [VL-1:0] b,
                          input logic [VL-1:0] c, input string req);
        @(negedge clk);
        src_a_i = a; src_b_i = b; acc_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(req, acc_o, model(a, b, c));
        check({req, " R6 done"}, VL'(done_o), VL'(1));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [VL-1:0] a, b, c, held;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 acc", acc_o, '0);
        check("R8 done", VL'(done_o), '0);
        rst = 1'b0;

        // R10 / R4: extreme products, wrap in each direction, one per lane (R5)
        a = {VL/8{8'hFF}};
        b = {VL/8{8'h80}};
        c = {32'hFFFFFFFF, 32'h00000000, 32'h80000000, 32'h7FFFFFFF};
        run_op(a, b, c, "R10/R4/R5 min");
        check("R10 min consts", acc_o, {32'hFFFE01FF, 32'hFFFE0200, 32'h7FFE0200, 32'h7FFE01FF});
        b = {VL/8{8'h7F}};
        run_op(a, b, c, "R10/R4/R5 max");
        check("R10 max consts", acc_o, {32'h0001FA03, 32'h0001FA04, 32'h8001FA04, 32'h8001FA03});

        // R9: zero sources pass the accumulator through
        c = {32'h12345678, 32'hDEADBEEF, 32'h00000001, 32'hFFFFFFFF};
        run_op('0, {VL/8{8'hA5}}, c, "R9 zero a");
        check("R9 a const", acc_o, c);
        run_op({VL/8{8'hC3}}, '0, c, "R9 zero b");
        check("R9 b const", acc_o, c);

        // R1: a single byte position isolates lane/byte placement
        for (int k = 0; k < VL/8; k++) begin
            a = '0; b = '0;
            a[8*k +: 8] = 8'd3;
            b[8*k +: 8] = 8'hFE;
            run_op(a, b, '0, "R1 position");
            held = '0;
            held[32*(k/4) +: 32] = 32'hFFFFFFFA;
            check("R1 position const", acc_o, held);
        end

        // R7: idle cycles with changing inputs hold output, no done
        held = acc_o;
        @(negedge clk);
        src_a_i = '1; src_b_i = '1; acc_i = '1;
        @(negedge clk);
        check("R7 hold", acc_o, held);
        check("R7 done low", VL'(done_o), '0);

        // R1-style sweep for R2/R3/R4: stride over unsigned, all signed values
        for (int ua = 0; ua < 256; ua += 3) begin
            for (int sb = -128; sb < 128; sb++) begin
                for (int k = 0; k < VL/8; k++) begin
                    a[8*k +: 8] = 8'(ua + 17*k);
                    b[8*k +: 8] = 8'(sb + 29*k);
                end
                c = {4{32'(ua * 1000003 + sb * 7919)}};
                c[31:0] = c[31:0] ^ 32'hF0F0F0F0;
                run_op(a, b, c, "R2/R3/R4 sweep");
            end
        end

        // R8: reset mid-run clears result
        rst = 1'b1;
        @(negedge clk);
        check("R8 midrun acc", acc_o, '0);
        check("R8 midrun done", VL'(done_o), '0);
        finish_run();
    end
endmodule